// File: doc/BRIEF.md
# Daisy-Chained FIFO Depth Expander

This block builds one deep first-in/first-out buffer out of several identical FIFO segments joined in a ring. Each segment has its own storage, its own write and read pointers and a word counter. Two tokens circulate around the ring: one for writing and one for reading. A write strobe is taken only by the segment that holds the write token, and a read strobe is served only by the segment that holds the read token. When a segment's write pointer or read pointer passes the last location of its storage, that segment hands the matching token on to the next segment through a pulse. The last segment hands on to the first, so that the whole chain behaves like one circular buffer of `NUM_SEG * SEG_DEPTH` words.

One segment is picked at reset as the starting holder of both tokens (`lead_sel`). A mode input instead makes segment 0 act alone as a standalone FIFO. In that mode the tokens never move, the segment's shared expansion output carries a half-full flag, and a retransmit pulse rewinds its read side. In chained mode the retransmit input does nothing and the shared expansion outputs carry only handoff pulses.

Top module: `fifo_token_chain`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `empty`=1, `full`=0, `rd_valid`=0, `rd_data`=0 and every `seg_xo` bit is 0. In chained mode (`solo_mode`=0) bit i of both `wr_owner` and `rd_owner` equals `lead_sel[i]`.
- R2: An accepted write is stored in the segment whose `wr_owner` bit is set. After that segment has taken `SEG_DEPTH` writes in a row, `wr_owner` moves to segment (i+1) mod `NUM_SEG` in the cycle right after the last write.
- R3: Words come out of `rd_data` in the order they were accepted. After `SEG_DEPTH` reads from one segment, `rd_owner` moves to segment (i+1) mod `NUM_SEG` in the cycle right after the last read.
- R4: In chained mode `full` is 1 exactly when `NUM_SEG*SEG_DEPTH` words are held. With one word fewer it is 0.
- R5: `empty` is 1 exactly when no word is held. A read strobe while `empty`=1 is ignored: `rd_valid` stays 0 in the next cycle.
- R6: A write strobe while `full`=1 is ignored. The word is never read back, and `wr_owner` does not change.
- R7: In chained mode `seg_xo[i]` is a one-cycle pulse. It is high in the cycle after segment i accepted the last write or the last read of its storage. A write wrap in one segment and a read wrap in another segment in the same cycle both move their tokens.
- R8: An accepted read gives `rd_valid`=1 with the word on `rd_data` in the next cycle. `rd_data` is 0 in every cycle where `rd_valid` is 0.
- R9: Any segment may be chosen as the starting holder through a one-hot `lead_sel`. Data order and capacity do not depend on that choice.
- R10: With `solo_mode`=1 at reset, segment 0 alone is used. Both owner outputs stay at 1 on bit 0 only, capacity is `SEG_DEPTH`, and `seg_xo[0]` is 1 exactly when more than `SEG_DEPTH/2` words are held.
- R11: In solo mode, a `retx` pulse sets the read side back to the first word written since reset. The held count becomes the number of writes since reset, which is valid while that number is below `SEG_DEPTH`. Strobes in the same cycle are ignored. In chained mode `retx` has no effect.
- R12: In chained mode no half-full indication is given: `seg_xo` stays 0 while more than half of a segment is filled, unless a handoff occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| solo_mode | input | 1 | 1: segment 0 works alone; sampled under reset |
| lead_sel | input | NUM_SEG | One-hot starting token holder in chained mode; sampled under reset |
| retx | input | 1 | Retransmit pulse, active in solo mode only |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write word |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read word, zero when not valid |
| rd_valid | output | 1 | Read word valid |
| full | output | 1 | Chain full |
| empty | output | 1 | Chain empty |
| seg_xo | output | NUM_SEG | Per-segment expansion output: handoff pulse in chained mode, half-full of segment 0 in solo mode |
| wr_owner | output | NUM_SEG | Current write-token holder, one-hot |
| rd_owner | output | NUM_SEG | Current read-token holder, one-hot |

## Verification
The bench fills the ring to exactly one word short of capacity and then to capacity. A design that flagged full from a single segment's count would raise `full` after 16 words instead of 48. It also pushes writes into a full chain, which a design with a leaky gate would store and later return out of order. Random traffic from a start segment other than 0 makes write wraps and read wraps land in the same cycle in different segments; a design that shared one token line would lose one token and stall or reorder. Solo mode is probed at the half-full boundary and with a rewind after partial reads, where an off-by-one in the count reload would replay too few or too many words.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // Token handoff channels carried from one segment to the next.
  typedef struct packed {
    logic wr;
    logic rd;
  } tok_pulse_t;

  function automatic int unsigned addr_bits(int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/fifo_seg_ram.sv
module fifo_seg_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 9,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // Plain synchronous write and registered read: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/fifo_seg.sv
module fifo_seg
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              solo_i,
  input  logic              lead_i,
  input  logic              rtx_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_stb_i,
  input  tok_pulse_t        tok_in_i,
  output tok_pulse_t        tok_out_o,
  output logic              xo_o,
  output logic              hold_w_o,
  output logic              hold_r_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);

  localparam int AW       = addr_bits(DEPTH);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int HALF     = DEPTH / 2;
  localparam bit IS_POW2  = ((DEPTH & (DEPTH - 1)) == 0);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr, rptr, wptr_inc, rptr_inc;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          hold_w, hold_r, full_q, empty_q, xo_q, vld_q;
  logic          rtx_go, do_wr, do_rd, w_wrap, r_wrap;
  logic [DATA_W-1:0] ram_q;

  // Pointer increment: natural wrap for power-of-two depths, compare otherwise.
  generate
    if (IS_POW2) begin : g_pow2_inc
      assign wptr_inc = wptr + 1'b1;
      assign rptr_inc = rptr + 1'b1;
    end else begin : g_cmp_inc
      assign wptr_inc = (wptr == LAST) ? '0 : wptr + 1'b1;
      assign rptr_inc = (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  endgenerate

  assign rtx_go = solo_i & rtx_i;
  assign do_wr  = wr_stb_i & hold_w & ~full_q  & ~rtx_go;
  assign do_rd  = rd_stb_i & hold_r & ~empty_q & ~rtx_go;
  assign w_wrap = do_wr & (wptr == LAST);
  assign r_wrap = do_rd & (rptr == LAST);

  // Handoff to the next segment happens on the same edge as the wrap.
  assign tok_out_o.wr = w_wrap & ~solo_i;
  assign tok_out_o.rd = r_wrap & ~solo_i;

  always_comb begin
    if (rtx_go) cnt_nxt = CW'(wptr);
    else        cnt_nxt = cnt + CW'(do_wr) - CW'(do_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      hold_w  <= lead_i;
      hold_r  <= lead_i;
      xo_q    <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr_inc;
      if (rtx_go)     rptr <= '0;
      else if (do_rd) rptr <= rptr_inc;
      cnt     <= cnt_nxt;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      empty_q <= (cnt_nxt == '0);
      if (tok_in_i.wr)       hold_w <= 1'b1;
      else if (tok_out_o.wr) hold_w <= 1'b0;
      if (tok_in_i.rd)       hold_r <= 1'b1;
      else if (tok_out_o.rd) hold_r <= 1'b0;
      xo_q  <= solo_i ? (cnt_nxt > CW'(HALF)) : (tok_out_o.wr | tok_out_o.rd);
      vld_q <= do_rd;
    end
  end

  fifo_seg_ram #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .AW    (AW)
  ) ram_i (
    .clk  (clk),
    .we   (do_wr),
    .waddr(wptr),
    .wdata(wr_data_i),
    .re   (do_rd),
    .raddr(rptr),
    .rdata(ram_q)
  );

  assign xo_o      = xo_q;
  assign hold_w_o  = hold_w;
  assign hold_r_o  = hold_r;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign rd_vld_o  = vld_q;
  assign rd_data_o = vld_q ? ram_q : '0;

  // R4/R6: occupancy never exceeds the segment's storage
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R7: each handoff channel pulses for one cycle only
  a_r7_wr_pulse_single: assert property (@(posedge clk) disable iff (rst)
    tok_out_o.wr |=> !tok_out_o.wr);
  a_r7_rd_pulse_single: assert property (@(posedge clk) disable iff (rst)
    tok_out_o.rd |=> !tok_out_o.rd);

  // R2: a segment without the write token leaves its write pointer alone
  a_r2_no_wtok_no_move: assert property (@(posedge clk) disable iff (rst)
    !hold_w |=> $stable(wptr));

  // R8: read data only comes from the segment that held the read token
  a_r8_vld_from_owner: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $past(hold_r));

endmodule

// File: rtl/fifo_chain_join.sv
module fifo_chain_join #(
  parameter int NUM_SEG = 3,
  parameter int DATA_W  = 9
) (
  input  logic [NUM_SEG-1:0]             seg_vld,
  input  logic [NUM_SEG-1:0][DATA_W-1:0] seg_data,
  input  logic [NUM_SEG-1:0]             seg_hold_w,
  input  logic [NUM_SEG-1:0]             seg_full,
  input  logic [NUM_SEG-1:0]             seg_hold_r,
  input  logic [NUM_SEG-1:0]             seg_empty,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_valid,
  output logic                           chain_full,
  output logic                           chain_empty
);

  // Segments zero their data when not valid, so an OR tree merges them.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SEG; i++) rd_data |= seg_data[i];
  end

  assign rd_valid    = |seg_vld;
  assign chain_full  = |(seg_hold_w & seg_full);
  assign chain_empty = |(seg_hold_r & seg_empty);

endmodule

// File: rtl/fifo_token_chain.sv
module fifo_token_chain
  import fifo_chain_pkg::*;
#(
  parameter int NUM_SEG   = 3,
  parameter int SEG_DEPTH = 16,
  parameter int DATA_W    = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               solo_mode,
  input  logic [NUM_SEG-1:0] lead_sel,
  input  logic               retx,
  input  logic               wr_stb,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_stb,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               full,
  output logic               empty,
  output logic [NUM_SEG-1:0] seg_xo,
  output logic [NUM_SEG-1:0] wr_owner,
  output logic [NUM_SEG-1:0] rd_owner
);

  tok_pulse_t                 tok_out [NUM_SEG];
  logic [NUM_SEG-1:0]         seg_vld, seg_hold_w, seg_hold_r, seg_full, seg_empty;
  logic [NUM_SEG-1:0][DATA_W-1:0] seg_data;

  generate
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      localparam int PREV = (i == 0) ? NUM_SEG - 1 : i - 1;
      logic solo_here, lead_here;
      assign solo_here = solo_mode & (i == 0);
      assign lead_here = solo_mode ? (i == 0) : lead_sel[i];

      fifo_seg #(
        .DEPTH (SEG_DEPTH),
        .DATA_W(DATA_W)
      ) seg_i (
        .clk      (clk),
        .rst      (rst),
        .solo_i   (solo_here),
        .lead_i   (lead_here),
        .rtx_i    (retx),
        .wr_stb_i (wr_stb),
        .wr_data_i(wr_data),
        .rd_stb_i (rd_stb),
        .tok_in_i (tok_out[PREV]),
        .tok_out_o(tok_out[i]),
        .xo_o     (seg_xo[i]),
        .hold_w_o (seg_hold_w[i]),
        .hold_r_o (seg_hold_r[i]),
        .full_o   (seg_full[i]),
        .empty_o  (seg_empty[i]),
        .rd_data_o(seg_data[i]),
        .rd_vld_o (seg_vld[i])
      );
    end
  endgenerate

  fifo_chain_join #(
    .NUM_SEG(NUM_SEG),
    .DATA_W (DATA_W)
  ) join_i (
    .seg_vld    (seg_vld),
    .seg_data   (seg_data),
    .seg_hold_w (seg_hold_w),
    .seg_full   (seg_full),
    .seg_hold_r (seg_hold_r),
    .seg_empty  (seg_empty),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .chain_full (full),
    .chain_empty(empty)
  );

  assign wr_owner = seg_hold_w;
  assign rd_owner = seg_hold_r;

  // R2: the write token is never duplicated
  a_r2_one_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_owner));
  // R3: the read token is never duplicated
  a_r3_one_reader: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_owner));
  // R8: at most one segment drives read data
  a_r8_one_valid: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg_vld));
  // R4/R5: full and empty never coincide
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  // R10: in solo mode the tokens stay at segment 0
  a_r10_solo_tokens_home: assert property (@(posedge clk) disable iff (rst)
    solo_mode |-> (wr_owner[0] && rd_owner[0]));

endmodule

// File: tb/fifo_token_chain_tb_top.sv
module fifo_token_chain_tb_top;

  localparam int N = 3;
  localparam int D = 16;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst, solo_mode, retx, wr_stb, rd_stb;
  logic [N-1:0] lead_sel;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic         rd_valid, full, empty;
  logic [N-1:0] seg_xo, wr_owner, rd_owner;

  always #5 clk = ~clk;

  fifo_token_chain #(.NUM_SEG(N), .SEG_DEPTH(D), .DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .solo_mode(solo_mode), .lead_sel(lead_sel),
    .retx(retx), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
    .seg_xo(seg_xo), .wr_owner(wr_owner), .rd_owner(rd_owner)
  );

  int n_run = 0;
  int n_fail = 0;

  // Reference model
  int m_q[$];
  int m_written[$];
  bit m_solo;
  int m_lead;
  int m_wtot, m_rtot;

  function automatic int cap();
    return m_solo ? D : N * D;
  endfunction

  function automatic int owner(int k);
    return m_solo ? 0 : (m_lead + k / D) % N;
  endfunction

  function automatic int onehot(int idx);
    return 1 << idx;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(bit solo, logic [N-1:0] lead, int lead_idx);
    @(negedge clk);
    rst = 1'b1; solo_mode = solo; lead_sel = lead;
    wr_stb = 1'b0; rd_stb = 1'b0; retx = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_q.delete(); m_written.delete();
    m_solo = solo; m_lead = lead_idx; m_wtot = 0; m_rtot = 0;
  endtask

  // One clock of stimulus with full output checking after the edge.
  task automatic cycle(bit wr, int d, bit rd, bit rt);
    bit rtx_eff, wacc, racc;
    int exp_data;
    int exp_xo;
    @(negedge clk);
    wr_stb = wr; wr_data = W'(d); rd_stb = rd; retx = rt;
    rtx_eff  = m_solo && rt;
    wacc     = wr && (m_q.size() < cap()) && !rtx_eff;
    racc     = rd && (m_q.size() > 0) && !rtx_eff;
    exp_data = racc ? m_q[0] : 0;
    exp_xo   = 0;
    if (!m_solo) begin
      if (wacc && (m_wtot % D == D - 1)) exp_xo |= onehot(owner(m_wtot));
      if (racc && (m_rtot % D == D - 1)) exp_xo |= onehot(owner(m_rtot));
    end
    if (racc) begin void'(m_q.pop_front()); m_rtot++; end
    if (wacc) begin
      m_q.push_back(d & 'h1FF);
      if (m_solo) m_written.push_back(d & 'h1FF);
      m_wtot++;
    end
    if (rtx_eff) m_q = m_written;
    if (m_solo) exp_xo = (m_q.size() > D / 2) ? 1 : 0;
    @(posedge clk);
    #1;
    chk("R8", "rd_valid", int'(rd_valid), int'(racc));
    chk("R3", "rd_data", int'(rd_data), exp_data);
    chk(m_solo ? "R10" : "R4", "full", int'(full), int'(m_q.size() == cap()));
    chk("R5", "empty", int'(empty), int'(m_q.size() == 0));
    chk("R2", "wr_owner", int'(wr_owner), onehot(owner(m_wtot)));
    chk("R3", "rd_owner", int'(rd_owner), onehot(owner(m_rtot)));
    chk(m_solo ? "R10" : "R7", "seg_xo", int'(seg_xo), exp_xo);
    wr_stb = 1'b0; rd_stb = 1'b0; retx = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1; solo_mode = 1'b0; lead_sel = 3'b001; retx = 1'b0;
    wr_stb = 1'b0; rd_stb = 1'b0; wr_data = '0;

    // R1: reset state, chained, lead 0
    do_reset(1'b0, 3'b001, 0);
    #1;
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    chk("R1", "seg_xo", int'(seg_xo), 0);
    chk("R1", "wr_owner", int'(wr_owner), 1);
    chk("R1", "rd_owner", int'(rd_owner), 1);

    // R5: read while empty ignored
    cycle(1'b0, 0, 1'b1, 1'b0);
    chk("R5", "read on empty valid", int'(rd_valid), 0);

    // R12: nine words in the first segment raise no indication
    for (int i = 0; i < 9; i++) cycle(1'b1, 16'h100 + i, 1'b0, 1'b0);
    chk("R12", "seg_xo above half", int'(seg_xo), 0);
    // R4: one short of capacity, then at capacity
    for (int i = 9; i < N * D - 1; i++) cycle(1'b1, 16'h100 + i, 1'b0, 1'b0);
    chk("R4", "full at 47", int'(full), 0);
    cycle(1'b1, 16'h100 + N * D - 1, 1'b0, 1'b0);
    chk("R4", "full at 48", int'(full), 1);
    chk("R2", "owner back at lead", int'(wr_owner), 1);
    // R6: writes while full are ignored
    for (int i = 0; i < 4; i++) cycle(1'b1, 16'h0AA, 1'b0, 1'b0);
    chk("R6", "full stays", int'(full), 1);
    chk("R6", "owner stays", int'(wr_owner), 1);
    // R3: drain in order (data checked per cycle)
    for (int i = 0; i < N * D; i++) cycle(1'b0, 0, 1'b1, 1'b0);
    chk("R5", "empty after drain", int'(empty), 1);
    cycle(1'b0, 0, 1'b1, 1'b0);
    chk("R6", "no stray word", int'(rd_valid), 0);

    // R11: retransmit ignored in chained mode
    do_reset(1'b0, 3'b010, 1);
    chk("R9", "lead 1 wr_owner", int'(wr_owner), 2);
    chk("R9", "lead 1 rd_owner", int'(rd_owner), 2);
    for (int i = 0; i < 3; i++) cycle(1'b1, 16'h40 + i, 1'b0, 1'b0);
    cycle(1'b0, 0, 1'b1, 1'b0);
    cycle(1'b0, 0, 1'b0, 1'b1);
    cycle(1'b0, 0, 1'b1, 1'b0);
    chk("R11", "chain retx no rewind", int'(rd_data), 16'h41);

    // R9 and R7: random traffic starting at segment 2
    do_reset(1'b0, 3'b100, 2);
    chk("R9", "lead 2 owner", int'(wr_owner), 4);
    for (int c = 0; c < 5000; c++) begin
      int pw, pr;
      pw = ((c / 500) % 2 == 0) ? 70 : 35;
      pr = 100 - pw;
      cycle(($urandom % 100) < pw, $urandom % 512, ($urandom % 100) < pr,
            ($urandom % 40) == 0);
    end

    // R10 / R11: solo mode, lead_sel ignored
    do_reset(1'b1, 3'b100, 0);
    chk("R10", "solo wr_owner", int'(wr_owner), 1);
    for (int i = 0; i < 8; i++) cycle(1'b1, 16'h20 + i, 1'b0, 1'b0);
    chk("R10", "hf at 8", int'(seg_xo), 0);
    cycle(1'b1, 16'h28, 1'b0, 1'b0);
    chk("R10", "hf at 9", int'(seg_xo), 1);
    for (int i = 0; i < 4; i++) cycle(1'b0, 0, 1'b1, 1'b0);
    chk("R10", "hf at 5", int'(seg_xo), 0);
    cycle(1'b1, 16'h1FF, 1'b1, 1'b1);
    chk("R11", "strobes ignored on retx", int'(rd_valid), 0);
    cycle(1'b0, 0, 1'b1, 1'b0);
    chk("R11", "replay first word", int'(rd_data), 16'h20);
    for (int i = 0; i < 30; i++) cycle(1'b1, 16'h60 + i, ($urandom % 4) == 0, 1'b0);
    chk("R10", "solo full at depth", int'(full), 1);
    chk("R10", "solo owner home", int'(rd_owner), 1);
    for (int i = 0; i < D + 1; i++) cycle(1'b0, 0, 1'b1, 1'b0);
    chk("R10", "solo empty", int'(empty), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule